// File: doc/BRIEF.md
# Programmable Audio Clock Generator

This block derives the three clocks of a serial audio link from a fast system clock: a master clock, a bit clock and a frame (word-select) clock. Each clock is produced as a registered level in the system clock domain, so every transition lands on a rising edge of `clk`. The master clock and the bit clock each have their own 10-bit divide ratio. The frame clock is counted in whole bit-clock periods and has a shaping mode: a one-period pulse, a 50% square wave, or separate 8-bit high and low lengths.

A sample-edge select input decides on which bit-clock edge data is launched. It also decides which phase of the bit clock gets the extra system-clock cycle when the divide ratio is odd. The frame clock always changes on the launch edge of the bit clock. The master clock has its own enable. The bit clock and the frame clock share a second enable. Ratios and modes are set while the matching enable is low. Dropping an enable forces its outputs low and clears its counters, so the next enable starts a fresh period.

Top module: `audio_clkgen`

## Requirements
- R1: With an even divide ratio N (2 to 1022), MCLK and BCLK are high for N/2 and low for N/2 system clocks.
- R2: A divide ratio of 0 gives a period of 1024 system clocks (512 high, 512 low). A ratio of 1 is treated as 2.
- R3: With an odd MCLK ratio N, MCLK is high for (N-1)/2 and low for (N+1)/2 system clocks.
- R4: With an odd BCLK ratio N, the low phase is the longer one ((N+1)/2) when `sample_pos` is 0. The high phase is the longer one when `sample_pos` is 1.
- R5: With `frame_mode` = 0, WCLK is high for one BCLK period and low for `frame_div[9:0]` BCLK periods.
- R6: With `frame_mode` = 1, WCLK is high and then low for `frame_div[9:0]` BCLK periods each.
- R7: With `frame_mode` = 2, WCLK is high for `frame_div[7:0]` and low for `frame_div[15:8]` BCLK periods.
- R8: `frame_mode` = 3 gives the same WCLK waveform as mode 0.
- R9: WCLK changes only in a cycle where BCLK makes its launch edge. That edge is the rising edge when `sample_pos` = 0 and the falling edge when `sample_pos` = 1.
- R10: In reset, and in the cycle after an enable is sampled low, the outputs of that enable are low. In the cycle after an enable is sampled high from the disabled state, MCLK and BCLK go high and begin a full period.
- R11: `mclk_en` acts only on MCLK, and `sclk_en` acts only on BCLK and WCLK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_en | input | 1 | Master clock enable |
| sclk_en | input | 1 | Bit and frame clock enable |
| mclk_ratio | input | 10 | Master clock divide ratio (0 means 1024) |
| bclk_ratio | input | 10 | Bit clock divide ratio (0 means 1024) |
| frame_div | input | 16 | Frame clock lengths in BCLK periods |
| frame_mode | input | 2 | 0 pulse, 1 half/half, 2 custom high/low, 3 same as 0 |
| sample_pos | input | 1 | 0 launch on BCLK rise, 1 launch on BCLK fall |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| wclk_o | output | 1 | Frame clock |

## Verification
The assertions check on every cycle that WCLK moves only together with the launch edge of BCLK. They also check that disabled outputs are low, that an enable begins with a high phase, and that no MCLK high run is longer than 512 cycles. The exact phase lengths cannot be seen one cycle at a time, so only the bench scenarios show them: the odd-ratio asymmetry and its flip with the sample edge, the 0 and 1 ratio encodings, and the WCLK lengths in each mode. The same holds for a restart beginning with a whole frame, and for each enable leaving the other clocks untouched.

// File: rtl/acg_pkg.sv
// Shared types for the audio clock generator.
// Assumes: the frame mode field is two bits wide.
package acg_pkg;
    typedef enum logic [1:0] {
        FRM_PULSE  = 2'd0,
        FRM_HALF   = 2'd1,
        FRM_CUSTOM = 2'd2,
        FRM_ALT    = 2'd3
    } frame_mode_e;
endpackage

// File: rtl/acg_div.sv
// Integer clock divider with a registered output level.
// It also gives combinational strobes that are true in the cycle before the
// output rises and the cycle before it falls, so that a downstream register
// can switch on the same clock edge as the output.
// Assumes: ratio_cfg and low_long are held stable while en is high.
module acg_div #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] ratio_cfg,
    input  logic             low_long,
    output logic             clk_o,
    output logic             rise_nx,
    output logic             fall_nx
);
    localparam int CNT_W  = DIV_W + 1;
    localparam int FULL_I = 1 << DIV_W;
    localparam logic [CNT_W-1:0] FULL = FULL_I[CNT_W-1:0];

    logic [CNT_W-1:0] eff;
    logic [CNT_W-1:0] hi_len;
    logic [CNT_W-1:0] cnt;

    // Effective ratio: 0 selects the largest ratio, 1 is raised to 2.
    always_comb begin
        if (ratio_cfg == '0)
            eff = FULL;
        else if (ratio_cfg == DIV_W'(1))
            eff = CNT_W'(2);
        else
            eff = {1'b0, ratio_cfg};
    end

    // High length: half the ratio, plus one for an odd ratio with a long high phase.
    always_comb hi_len = (eff >> 1) + {{(CNT_W-1){1'b0}}, eff[0] & ~low_long};

    // Strobes that announce the next output edge.
    always_comb begin
        rise_nx = en && (cnt == '0);
        fall_nx = en && (cnt == hi_len);
    end

    // Period counter and output level; both are cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt   <= '0;
            clk_o <= 1'b0;
        end else begin
            clk_o <= (cnt < hi_len);
            cnt   <= (cnt == eff - CNT_W'(1)) ? '0 : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/acg_frame.sv
// Frame clock shaper: counts launch strobes (one per BCLK period) through a
// frame made of a high segment and a low segment, chosen by the mode.
// Assumes: wdiv and mode are held stable while en is high. A zero length is
// raised to one period.
module acg_frame
    import acg_pkg::*;
#(
    parameter int WD_W  = 16,
    parameter int LEN_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            stb,
    input  logic [1:0]      mode,
    input  logic [WD_W-1:0] wdiv,
    output logic            wclk_o
);
    localparam int HALF_W = WD_W / 2;
    localparam int PER_W  = LEN_W + 1;

    frame_mode_e      fmode;
    logic [LEN_W-1:0] half_len;
    logic [LEN_W-1:0] c_hi;
    logic [LEN_W-1:0] c_lo;
    logic [LEN_W-1:0] hi_p;
    logic [LEN_W-1:0] lo_p;
    logic [PER_W-1:0] per;
    logic [PER_W-1:0] pcnt;

    // Field extraction with zero lengths raised to one.
    always_comb begin
        fmode    = frame_mode_e'(mode);
        half_len = (wdiv[LEN_W-1:0] == '0) ? LEN_W'(1) : wdiv[LEN_W-1:0];
        c_hi     = (wdiv[HALF_W-1:0] == '0) ? LEN_W'(1) : LEN_W'(wdiv[HALF_W-1:0]);
        c_lo     = (wdiv[WD_W-1:HALF_W] == '0) ? LEN_W'(1) : LEN_W'(wdiv[WD_W-1:HALF_W]);
    end

    // Mode decode into high and low segment lengths.
    always_comb begin
        case (fmode)
            FRM_HALF:   begin hi_p = half_len; lo_p = half_len; end
            FRM_CUSTOM: begin hi_p = c_hi;     lo_p = c_lo;     end
            default:    begin hi_p = LEN_W'(1); lo_p = half_len; end
        endcase
        per = {1'b0, hi_p} + {1'b0, lo_p};
    end

    // Frame position counter and level, advanced on each launch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pcnt   <= '0;
            wclk_o <= 1'b0;
        end else if (stb) begin
            wclk_o <= (pcnt < {1'b0, hi_p});
            pcnt   <= (pcnt == per - PER_W'(1)) ? '0 : pcnt + PER_W'(1);
        end
    end
endmodule

// File: rtl/audio_clkgen.sv
// Audio clock generator top: an MCLK divider, a BCLK divider and a WCLK
// shaper clocked by BCLK launch strobes.
// Assumes: configuration inputs change only while the matching enable is low.
module audio_clkgen #(
    parameter int DIV_W  = 10,
    parameter int FDIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclk_en,
    input  logic              sclk_en,
    input  logic [DIV_W-1:0]  mclk_ratio,
    input  logic [DIV_W-1:0]  bclk_ratio,
    input  logic [FDIV_W-1:0] frame_div,
    input  logic [1:0]        frame_mode,
    input  logic              sample_pos,
    output logic              mclk_o,
    output logic              bclk_o,
    output logic              wclk_o
);
    logic m_rise_nx, m_fall_nx;
    logic b_rise_nx, b_fall_nx;
    logic launch_nx;

    acg_div #(.DIV_W(DIV_W)) u_mdiv (
        .clk(clk), .rst_n(rst_n), .en(mclk_en), .ratio_cfg(mclk_ratio),
        .low_long(1'b1), .clk_o(mclk_o), .rise_nx(m_rise_nx), .fall_nx(m_fall_nx)
    );

    acg_div #(.DIV_W(DIV_W)) u_bdiv (
        .clk(clk), .rst_n(rst_n), .en(sclk_en), .ratio_cfg(bclk_ratio),
        .low_long(~sample_pos), .clk_o(bclk_o), .rise_nx(b_rise_nx), .fall_nx(b_fall_nx)
    );

    // Launch edge choice follows the sample-edge select.
    always_comb launch_nx = sample_pos ? b_fall_nx : b_rise_nx;

    acg_frame #(.WD_W(FDIV_W), .LEN_W(DIV_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .en(sclk_en), .stb(launch_nx),
        .mode(frame_mode), .wdiv(frame_div), .wclk_o(wclk_o)
    );
endmodule

// File: rtl/acg_chk.sv
// Port-level checker for the audio clock generator, bound to the top.
module acg_chk (
    input logic clk,
    input logic rst_n,
    input logic mclk_en,
    input logic sclk_en,
    input logic sample_pos,
    input logic mclk_o,
    input logic bclk_o,
    input logic wclk_o
);
    logic [10:0] m_run;

    // Length of the current MCLK high run.
    always_ff @(posedge clk) begin
        if (!rst_n || !mclk_o) m_run <= '0;
        else                   m_run <= m_run + 11'd1;
    end

    AST_WCLK_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sclk_en) && (wclk_o != $past(wclk_o))) |->
            (sample_pos ? $fell(bclk_o) : $rose(bclk_o))); // R9

    AST_MCLK_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mclk_en) |-> !mclk_o); // R10

    AST_SCLK_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sclk_en) |-> (!bclk_o && !wclk_o)); // R10

    AST_MCLK_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mclk_en) && !$past(mclk_en, 2)) |-> mclk_o); // R10

    AST_BCLK_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sclk_en) && !$past(sclk_en, 2)) |-> bclk_o); // R10

    AST_MCLK_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_o |-> (m_run < 11'd512)); // R2
endmodule

bind audio_clkgen acg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .sclk_en(sclk_en),
    .sample_pos(sample_pos), .mclk_o(mclk_o), .bclk_o(bclk_o), .wclk_o(wclk_o)
);

// File: tb/sim_audio_clkgen.sv
module sim_audio_clkgen;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    // Vector table: configuration, then expected high/low lengths in system clocks.
    localparam int V_MR[NV]  = '{4, 5, 5, 0, 7, 2};
    localparam int V_BR[NV]  = '{4, 5, 3, 1, 6, 7};
    localparam int V_FD[NV]  = '{3, 2, 16'h0302, 5, 4, 1};
    localparam int V_FM[NV]  = '{0, 1, 2, 3, 1, 0};
    localparam int V_SP[NV]  = '{0, 0, 1, 0, 1, 1};
    localparam int E_MH[NV]  = '{2, 2, 2, 512, 3, 1};
    localparam int E_ML[NV]  = '{2, 3, 3, 512, 4, 1};
    localparam int E_BH[NV]  = '{2, 2, 2, 1, 3, 4};
    localparam int E_BL[NV]  = '{2, 3, 1, 1, 3, 3};
    localparam int E_WH[NV]  = '{4, 10, 6, 2, 24, 7};
    localparam int E_WL[NV]  = '{12, 10, 9, 10, 24, 7};
    localparam string V_RQ[NV] = '{"R1 R5", "R3 R4 R6", "R4 R7", "R2 R8", "R3 R6", "R4 R5"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk_en = 1'b0, sclk_en = 1'b0;
    logic [9:0] mclk_ratio = '0, bclk_ratio = '0;
    logic [15:0] frame_div = '0;
    logic [1:0] frame_mode = '0;
    logic sample_pos = 1'b0;
    logic mclk_o, bclk_o, wclk_o;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .sclk_en(sclk_en),
        .mclk_ratio(mclk_ratio), .bclk_ratio(bclk_ratio), .frame_div(frame_div),
        .frame_mode(frame_mode), .sample_pos(sample_pos),
        .mclk_o(mclk_o), .bclk_o(bclk_o), .wclk_o(wclk_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int w);
        return (w == 0) ? mclk_o : (w == 1) ? bclk_o : wclk_o;
    endfunction

    // Measure one full high run and the following low run of an output.
    task automatic measure(input int w, output int hi, output int lo);
        while (pick(w) != 1'b0) @(negedge clk);
        while (pick(w) == 1'b0) @(negedge clk);
        hi = 0;
        while (pick(w) == 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (pick(w) == 1'b0) begin lo++; @(negedge clk); end
    endtask

    task automatic config_run(input int mr, input int br, input int fd, input int fm, input int sp);
        @(negedge clk);
        mclk_en = 1'b0; sclk_en = 1'b0;
        @(negedge clk);
        mclk_ratio = 10'(mr); bclk_ratio = 10'(br); frame_div = 16'(fd);
        frame_mode = 2'(fm); sample_pos = sp[0];
        @(negedge clk);
        mclk_en = 1'b1; sclk_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hi, lo, cnt_b, cnt_w, cnt_m, bad;
        logic pb, pw;
        // Reset state with the enables driven high (R10).
        mclk_en = 1'b1; sclk_en = 1'b1; mclk_ratio = 10'd4; bclk_ratio = 10'd4;
        repeat (4) @(negedge clk);
        chk(!mclk_o && !bclk_o && !wclk_o, "R10 reset", {mclk_o, bclk_o, wclk_o}, 0);
        mclk_en = 1'b0; sclk_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            config_run(V_MR[i], V_BR[i], V_FD[i], V_FM[i], V_SP[i]);
            measure(0, hi, lo);
            chk(hi == E_MH[i] && lo == E_ML[i], {V_RQ[i], " mclk"}, hi * 10000 + lo, E_MH[i] * 10000 + E_ML[i]);
            measure(1, hi, lo);
            chk(hi == E_BH[i] && lo == E_BL[i], {V_RQ[i], " bclk"}, hi * 10000 + lo, E_BH[i] * 10000 + E_BL[i]);
            measure(2, hi, lo);
            chk(hi == E_WH[i] && lo == E_WL[i], {V_RQ[i], " wclk"}, hi * 10000 + lo, E_WH[i] * 10000 + E_WL[i]);
        end

        // Start phase: high in the cycle after enable (R10).
        config_run(4, 4, 3, 0, 0);
        @(negedge clk);
        chk(mclk_o && bclk_o && wclk_o, "R10 start high", {mclk_o, bclk_o, wclk_o}, 7);

        // Launch-edge alignment for both sample-edge settings (R9).
        for (int s = 0; s < 2; s++) begin
            config_run(4, 6, 2, 1, s);
            bad = 0; cnt_w = 0;
            pb = bclk_o; pw = wclk_o;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                if (wclk_o != pw) begin
                    cnt_w++;
                    if (s == 0 && !(!pb && bclk_o)) bad++;
                    if (s == 1 && !(pb && !bclk_o)) bad++;
                end
                pb = bclk_o; pw = wclk_o;
            end
            chk(bad == 0 && cnt_w > 4, "R9 wclk on launch edge", bad, 0);
        end

        // Enables act independently (R11).
        config_run(4, 4, 3, 0, 0);
        sclk_en = 1'b0;
        cnt_m = 0; cnt_b = 0; cnt_w = 0;
        @(negedge clk);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            cnt_m += mclk_o; cnt_b += bclk_o; cnt_w += wclk_o;
        end
        chk(cnt_b == 0 && cnt_w == 0 && cnt_m == 20, "R11 sclk_en off, mclk runs", cnt_b + cnt_w + cnt_m, 20);
        mclk_en = 1'b0; sclk_en = 1'b1;
        cnt_m = 0; cnt_b = 0;
        @(negedge clk);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            cnt_m += mclk_o; cnt_b += bclk_o;
        end
        chk(cnt_m == 0 && cnt_b == 20, "R11 mclk_en off, bclk runs", cnt_m * 100 + cnt_b, 20);

        // Mid-run disable then restart with a whole first frame (R10).
        config_run(4, 4, 3, 0, 0);
        repeat (7) @(negedge clk);
        sclk_en = 1'b0; mclk_en = 1'b0;
        @(negedge clk);
        chk(!mclk_o && !bclk_o && !wclk_o, "R10 disable low", {mclk_o, bclk_o, wclk_o}, 0);
        sclk_en = 1'b1;
        @(negedge clk);
        hi = 0;
        while (wclk_o) begin hi++; @(negedge clk); end
        chk(hi == 4, "R10 restart full frame high", hi, 4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule